// File: doc/BRIEF.md
# Minute-resolution alarm comparator

This block watches a running calendar and raises an alarm when the calendar reaches a programmed minute, hour, day of month and weekday. The calendar counter lies outside the block. Its seconds, minutes, hours, day, weekday values arrive as raw BCD inputs. Software programs four alarm fields and a control byte through a simple single-cycle register port. Each field carries a disable bit in bit 7. A disabled field takes no part in the comparison and always counts as a hit.

The comparison is made once per minute, in the cycle in which the seconds input changes to 00 from a non-zero value. When every field hits in that cycle, an alarm flag is latched. The flag is latched even when the alarm interrupt enable is clear. The active-low interrupt pin is a level. It stays low for as long as both the flag and the enable are set. Software ends it by writing 0 to the flag bit.

Top module: `alm_unit`

## Requirements
- R1: After reset the control register (address 0x01) reads 0x00, each alarm register (0x09 to 0x0C) reads 0x80, and `alarm_irq_n` is high.
- R2: The alarm registers sit at 0x09 (minute), 0x0A (hour), 0x0B (day of month) and 0x0C (weekday). Bit 7 of each is its disable bit. The value bits are kept as written in 7, 6, 6 and 3 bits respectively, so a read returns the write data ANDed with 0xFF, 0xBF, 0xBF and 0x87.
- R3: Control register bits 4 (timer pulse select), 2 (timer flag), 1 (alarm interrupt enable) and 0 (timer interrupt enable) store the written value and read it back. Bits 7 to 5 read 0.
- R4: Writing 0 to control bit 3 (the alarm flag) clears it. Writing 1 to it leaves it as it was.
- R5: The match is evaluated only in a cycle in which the seconds input is 00 and was non-zero in the previous cycle. The flag reads set from the following cycle. Holding seconds at 00 produces no further evaluation.
- R6: An enabled field hits only when its stored value equals the masked calendar value bit for bit. A disabled field always hits. The flag is set only when all four fields hit.
- R7: With all four disable bits set, the flag is set at every minute boundary.
- R8: The flag is set on a match whether or not the alarm interrupt enable is set.
- R9: `alarm_irq_n` is low exactly when the alarm flag and the alarm interrupt enable are both set.
- R10: When a match and a write that clears the flag fall in the same cycle, the flag ends up set.
- R11: Writes to addresses other than 0x01 and 0x09 to 0x0C change nothing, and reads of those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_mday | input | 6 | Calendar day of month, BCD |
| cal_wday | input | 3 | Calendar weekday |
| alarm_irq_n | output | 1 | Active-low level alarm interrupt |

## Verification
Random alarm settings are paired with calendar values that are forced equal, field by field, about half the time. This covers full matches, single-field mismatches and mixes of disabled and enabled fields, so a faulty mask width or a wrong disable polarity shows up as a flag that differs from the bench's model. Directed cases hold seconds at 00 across a flag clear, which separates edge-based evaluation from level-based evaluation. They collide a clearing write with a match, and they toggle the enable around a latched flag to show that the flag and the pin are kept apart.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 8;
  localparam int VAL_W  = 7;   // widest field value
  localparam int NFIELD = 4;

  localparam logic [REG_AW-1:0] ADR_CTRL = 4'h1;
  localparam logic [REG_AW-1:0] ADR_ALM0 = 4'h9;   // first of four alarm fields

  localparam int CB_PULSE = 4;
  localparam int CB_AFLAG = 3;
  localparam int CB_TFLAG = 2;
  localparam int CB_AEN   = 1;
  localparam int CB_TEN   = 0;
  localparam int DIS_BIT  = 7;

  // Bits a field register keeps: its disable bit plus w value bits.
  function automatic logic [REG_DW-1:0] field_keep(input int w);
    logic [REG_DW-1:0] m;
    m = '0;
    for (int b = 0; b < w; b++) m[b] = 1'b1;
    m[DIS_BIT] = 1'b1;
    return m;
  endfunction

  // One field hits when disabled or when values are equal.
  function automatic logic field_hit(input logic dis,
                                     input logic [VAL_W-1:0] want,
                                     input logic [VAL_W-1:0] have);
    return dis | (want == have);
  endfunction

  function automatic logic [REG_DW-1:0] ctrl_keep();
    logic [REG_DW-1:0] m;
    m = '0;
    m[CB_PULSE] = 1'b1;
    m[CB_TFLAG] = 1'b1;
    m[CB_AEN]   = 1'b1;
    m[CB_TEN]   = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/alm_minute_tick.sv
module alm_minute_tick #(
  parameter int SEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] sec,
  output logic             tick
);
  logic [SEC_W-1:0] sec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_q <= '0;
    else        sec_q <= sec;
  end

  assign tick = (sec == '0) && (sec_q != '0);

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R5
  AST_TICK_NEEDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (sec == '0)); // R5
endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
  import alm_pkg::*;
#(
  parameter int W = 7
) (
  input  logic [REG_DW-1:0] alm_reg,
  input  logic [W-1:0]      have,
  output logic              hit
);
  logic [VAL_W-1:0] want_v;
  logic [VAL_W-1:0] have_v;

  always_comb begin
    want_v = '0;
    have_v = '0;
    want_v[W-1:0] = alm_reg[W-1:0];
    have_v[W-1:0] = have;
  end

  assign hit = field_hit(alm_reg[DIS_BIT], want_v, have_v);

  always_comb begin
    if (alm_reg[DIS_BIT]) AST_DIS_HITS: assert (hit); // R6
  end
endmodule

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 6,
  parameter int WDAY_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr,
  input  logic [REG_AW-1:0]             addr,
  input  logic [REG_DW-1:0]             wdata,
  output logic [REG_DW-1:0]             rdata,
  input  logic                          set_evt,
  output logic [NFIELD-1:0][REG_DW-1:0] alm_q,
  output logic                          aflag,
  output logic                          aen
);
  localparam logic [REG_DW-1:0] CKEEP = ctrl_keep();

  logic [REG_DW-1:0] ctl_q;
  logic              aflag_q;
  logic              ctl_wr;
  logic              flag_clr;

  assign ctl_wr   = wr && (addr == ADR_CTRL);
  assign flag_clr = ctl_wr && !wdata[CB_AFLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (ctl_wr) ctl_q <= wdata & CKEEP;
  end

  // Match wins over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        aflag_q <= 1'b0;
    else if (set_evt)  aflag_q <= 1'b1;
    else if (flag_clr) aflag_q <= 1'b0;
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    localparam int FW = (i == 0) ? MIN_W : (i == 1) ? HOUR_W :
                        (i == 2) ? DAY_W : WDAY_W;
    localparam logic [REG_DW-1:0] KEEP = field_keep(FW);
    localparam logic [REG_AW-1:0] ADR  = ADR_ALM0 + REG_AW'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     alm_q[i] <= 8'h80;
      else if (wr && (addr == ADR))   alm_q[i] <= wdata & KEEP;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADR_CTRL) begin
      rdata = ctl_q;
      rdata[CB_AFLAG] = aflag_q;
    end else begin
      for (int i = 0; i < NFIELD; i++)
        if (addr == ADR_ALM0 + REG_AW'(i)) rdata = alm_q[i];
    end
  end

  assign aflag = aflag_q;
  assign aen   = ctl_q[CB_AEN];

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> aflag_q); // R5
  AST_FLAG_ROSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aflag_q) |-> $past(set_evt)); // R8
  AST_FLAG_KEEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (aflag_q && !(wr && addr == ADR_CTRL && !wdata[CB_AFLAG])) |=> aflag_q); // R4
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADR_CTRL) |-> (rdata[7:5] == 3'b000)); // R3
endmodule

// File: rtl/alm_unit.sv
module alm_unit
  import alm_pkg::*;
#(
  parameter int SEC_W  = 7,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DAY_W  = 6,
  parameter int WDAY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [SEC_W-1:0]  cal_sec,
  input  logic [MIN_W-1:0]  cal_min,
  input  logic [HOUR_W-1:0] cal_hour,
  input  logic [DAY_W-1:0]  cal_mday,
  input  logic [WDAY_W-1:0] cal_wday,
  output logic              alarm_irq_n
);
  logic [NFIELD-1:0][REG_DW-1:0] alm_q;
  logic [NFIELD-1:0][VAL_W-1:0]  cal_v;
  logic [NFIELD-1:0]             hit;
  logic                          minute_tick;
  logic                          set_evt;
  logic                          aflag;
  logic                          aen;

  alm_minute_tick #(.SEC_W(SEC_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .sec(cal_sec), .tick(minute_tick));

  always_comb begin
    cal_v = '0;
    cal_v[0][MIN_W-1:0]  = cal_min;
    cal_v[1][HOUR_W-1:0] = cal_hour;
    cal_v[2][DAY_W-1:0]  = cal_mday;
    cal_v[3][WDAY_W-1:0] = cal_wday;
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_cmp
    alm_field_cmp #(.W(VAL_W)) u_cmp (
      .alm_reg(alm_q[i]), .have(cal_v[i]), .hit(hit[i]));
  end

  assign set_evt = minute_tick && (&hit);

  alm_regs #(.MIN_W(MIN_W), .HOUR_W(HOUR_W), .DAY_W(DAY_W), .WDAY_W(WDAY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .set_evt(set_evt), .alm_q(alm_q), .aflag(aflag), .aen(aen));

  assign alarm_irq_n = ~(aflag & aen);

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_irq_n) |-> ($rose(aflag) || $rose(aen))); // R9
  AST_NO_EVT_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |-> (cal_sec == '0)); // R5
  AST_ALL_DIS_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (minute_tick && alm_q[0][7] && alm_q[1][7] && alm_q[2][7] && alm_q[3][7])
      |=> aflag); // R7
endmodule

// File: tb/alm_unit_tb.sv
module alm_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [6:0] cal_sec = 7'h05;
  logic [6:0] cal_min = '0;
  logic [5:0] cal_hour = '0;
  logic [5:0] cal_mday = '0;
  logic [2:0] cal_wday = '0;
  logic       alarm_irq_n;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  alm_unit dut_i (.*);

  function automatic logic [7:0] keep_of(input int f);
    case (f)
      0: return 8'hFF;
      1: return 8'hBF;
      2: return 8'hBF;
      default: return 8'h87;
    endcase
  endfunction

  function automatic logic exp_match(input logic [7:0] a0, a1, a2, a3,
                                     input logic [6:0] m, input logic [5:0] h,
                                     input logic [5:0] d, input logic [2:0] w);
    logic ok;
    ok = 1'b1;
    if (!a0[7] && a0[6:0] != m) ok = 1'b0;
    if (!a1[7] && a1[5:0] != h) ok = 1'b0;
    if (!a2[7] && a2[5:0] != d) ok = 1'b0;
    if (!a3[7] && a3[2:0] != w) ok = 1'b0;
    return ok;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Drive seconds 59 then 00 with the given calendar; return at the negedge
  // after the evaluating posedge.
  task automatic boundary(input logic [6:0] m, input logic [5:0] h,
                          input logic [5:0] d, input logic [2:0] w);
    @(negedge clk);
    cal_sec = 7'h59;
    @(negedge clk);
    cal_sec = 7'h00; cal_min = m; cal_hour = h; cal_mday = d; cal_wday = w;
    @(negedge clk);
  endtask

  task automatic leave_zero();
    @(negedge clk);
    cal_sec = 7'h01;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] a [4];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h1, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
    for (int f = 0; f < 4; f++) begin
      rd(4'(9 + f), v); chk(v == 8'h80, "R1 alarm reg", v, 8'h80);
    end
    chk(alarm_irq_n == 1'b1, "R1 irq_n", alarm_irq_n, 1);

    // R2 masked readback
    for (int f = 0; f < 4; f++) begin
      wr(4'(9 + f), 8'hFF);
      rd(4'(9 + f), v); chk(v == keep_of(f), "R2 keep mask", v, keep_of(f));
      wr(4'(9 + f), 8'h5A);
      rd(4'(9 + f), v); chk(v == (8'h5A & keep_of(f)), "R2 value", v, 8'h5A & keep_of(f));
    end

    // R3 / R4 control bits, flag write-1 has no effect when clear
    wr(4'h1, 8'hFF);
    rd(4'h1, v); chk(v == 8'h17, "R3 ctrl all ones", v, 8'h17);
    chk(alarm_irq_n == 1'b1, "R4 write-1 keeps flag clear", alarm_irq_n, 1);
    wr(4'h1, 8'h00);
    rd(4'h1, v); chk(v == 8'h00, "R3 ctrl zero", v, 8'h00);

    // R11 unmapped address
    wr(4'h5, 8'hFF); wr(4'hF, 8'hFF); wr(4'h0, 8'hFF);
    rd(4'h5, v); chk(v == 8'h00, "R11 unmapped read", v, 0);
    rd(4'h1, v); chk(v == 8'h00, "R11 ctrl untouched", v, 0);
    rd(4'h9, v); chk(v == 8'h5A, "R11 alarm untouched", v, 8'h5A);

    // R7 / R8 all fields disabled, enable clear
    for (int f = 0; f < 4; f++) wr(4'(9 + f), 8'h80);
    boundary(7'h33, 6'h11, 6'h07, 3'd2);
    rd(4'h1, v); chk(v[3] == 1'b1, "R7 all disabled sets flag", v, 8'h08);
    chk(alarm_irq_n == 1'b1, "R8 pin gated by enable", alarm_irq_n, 1);
    // R5 seconds held at 00: clear and no refire
    wr(4'h1, 8'h00);
    repeat (3) @(negedge clk);
    rd(4'h1, v); chk(v[3] == 1'b0, "R5 no refire while held at 00", v[3], 0);
    // R5 re-entry from non-zero
    leave_zero();
    @(negedge clk); cal_sec = 7'h00;
    @(negedge clk);
    rd(4'h1, v); chk(v[3] == 1'b1, "R5 fires on non-zero to 00", v[3], 1);

    // R9 / R4 enable after latch, write-1 keeps flag
    wr(4'h1, 8'h0A);
    rd(4'h1, v); chk(v == 8'h0A, "R4 write-1 keeps flag set", v, 8'h0A);
    chk(alarm_irq_n == 1'b0, "R9 irq low with flag and enable", alarm_irq_n, 0);
    wr(4'h1, 8'h02);
    chk(alarm_irq_n == 1'b1, "R9 irq released on clear", alarm_irq_n, 1);
    leave_zero();

    // R6 single enabled field
    wr(4'hA, 8'h12);
    boundary(7'h00, 6'h13, 6'h01, 3'd0);
    rd(4'h1, v); chk(v[3] == 1'b0, "R6 hour mismatch", v[3], 0);
    leave_zero();
    boundary(7'h45, 6'h12, 6'h29, 3'd6);
    rd(4'h1, v); chk(v[3] == 1'b1, "R6 hour match", v[3], 1);
    chk(alarm_irq_n == 1'b0, "R9 irq low on match", alarm_irq_n, 0);
    wr(4'h1, 8'h02);
    leave_zero();

    // R10 clear collides with match
    @(negedge clk); cal_sec = 7'h59;
    @(negedge clk);
    cal_sec = 7'h00; cal_hour = 6'h12;
    reg_wr = 1'b1; reg_addr = 4'h1; reg_wdata = 8'h02;
    @(negedge clk); reg_wr = 1'b0;
    rd(4'h1, v); chk(v[3] == 1'b1, "R10 set wins over clear", v[3], 1);
    wr(4'h1, 8'h02);
    leave_zero();

    // R6 / R8 random patterns
    for (int it = 0; it < 40; it++) begin
      logic [6:0] m; logic [5:0] h; logic [5:0] d; logic [2:0] w;
      logic en, e;
      for (int f = 0; f < 4; f++) begin
        a[f] = 8'($urandom) & keep_of(f);
        a[f][7] = ($urandom % 4) == 0;
      end
      m = 7'($urandom); h = 6'($urandom); d = 6'($urandom); w = 3'($urandom);
      if ($urandom % 2) m = a[0][6:0];
      if ($urandom % 2) h = a[1][5:0];
      if ($urandom % 2) d = a[2][5:0];
      if ($urandom % 2) w = a[3][2:0];
      if (($urandom % 3) == 0) begin
        m = a[0][6:0]; h = a[1][5:0]; d = a[2][5:0]; w = a[3][2:0];
      end
      en = 1'($urandom);
      for (int f = 0; f < 4; f++) wr(4'(9 + f), a[f]);
      wr(4'h1, {6'b0, en, 1'b0});
      e = exp_match(a[0], a[1], a[2], a[3], m, h, d, w);
      boundary(m, h, d, w);
      rd(4'h1, v); chk(v[3] == e, "R6 random match", v[3], e);
      chk(alarm_irq_n == !(e && en), "R8 R9 random pin", alarm_irq_n, !(e && en));
      leave_zero();
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule